// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block holds the operating mode of a synchronous DRAM device and turns each read or write command into the column address for every data beat of the burst. A mode-set command loads a 15-bit word. The low thirteen bits come from the address pins and the top two come from the bank-select pins. The block decodes three things from that word: the burst length, the column ordering (wrapping sequential or interleaved) and the access latency. The latency is stored and shown on a port. It does not delay anything here.

A mode-set is taken only while every bank reports idle and the word holds a legal combination. Any other attempt leaves the stored mode unchanged and raises an error strobe for one cycle. Until the first accepted mode-set the block reports itself unprogrammed and ignores read and write commands. A full-page burst walks the whole 256-column page with wrap-around until a stop input ends it. A new command at any time restarts the sequence from its own start column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Fields of the mode word: bits 2:0 are the length code (000=1 beat, 001=2, 010=4, 011=8, 111=full page); bit 3 picks the ordering (0 sequential, 1 interleaved); bits 6:4 are the latency, which shows on `cas_lat` from the cycle after an accepted mode-set. The other bits are ignored.
- R2: After reset `programmed` is 0 and `cas_lat` is 0. `programmed` goes to 1 in the cycle after the first accepted mode-set and then stays at 1 until the next reset.
- R3: While `programmed` is 0, read and write commands start no burst: `col_valid` stays 0.
- R4: A mode-set issued while any bit of `bank_idle` is 0 changes nothing, and `mrs_err` is 1 for exactly the following cycle.
- R5: A mode-set with a reserved length code (100, 101, 110), or with code 111 together with interleaved ordering, keeps the previous mode and pulses `mrs_err` for one cycle.
- R6: A read or write command sampled while programmed makes `col_valid` high for the next BL cycles. The first beat's `col_out` equals the start column.
- R7: Sequential ordering: beat n carries the start column with its low log2(BL) bits replaced by (those bits + n) mod BL. The upper bits are unchanged.
- R8: Interleaved ordering: beat n carries the start column with its low log2(BL) bits XORed with n.
- R9: Full page: beat n carries (start + n) mod 256. The burst runs until `burst_stop` is sampled high, and `col_valid` is 0 from the next cycle on.
- R10: `burst_stop` sampled high during any burst ends it: `col_valid` is 0 in the following cycle.
- R11: A command sampled during an active burst restarts the sequence in the next cycle from the new start column, using the mode held at that edge.
- R12: `col_wr` is 1 during the beats of a write burst and 0 during the beats of a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_cmd | input | 1 | Mode-set command strobe |
| mrs_word | input | 15 | Mode word: bits 12:0 address pins, bits 14:13 bank selects |
| bank_idle | input | NBANK | Per-bank idle indication |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| start_col | input | COLW | Start column of the command |
| burst_stop | input | 1 | Burst terminate request |
| programmed | output | 1 | A valid mode has been loaded |
| mrs_err | output | 1 | One-cycle pulse on a rejected mode-set |
| cas_lat | output | 3 | Stored latency field |
| col_valid | output | 1 | A burst beat is presented |
| col_wr | output | 1 | The current beat belongs to a write burst |
| col_out | output | COLW | Column address of the current beat |

## Verification
The hardest situation to reach is a command that lands in the middle of a running burst, in the same cycle as a stop request or a mode change. In that case the restart has to use the mode held before the edge and must take priority over the stop. The stimulus programs a long burst, issues a second command partway through it, and later raises a command, a stop and a mode-set together. A behavioural model built on integer arithmetic follows every cycle, so a stale mode, a lost restart or a miscounted beat shows up as a mismatch in the very cycle it happens. Full-page wrap is reached by starting four columns below the page end, and interleaved ordering is checked with a start column whose low bits are not aligned.

// File: rtl/burst_pkg.sv
// Shared types and helpers for the burst column generator.
// Assumes the mode word layout given in the brief (length code in bits 2:0).
package burst_pkg;

    // Decoded contents of the mode word that the block keeps.
    typedef struct packed {
        logic [2:0] cas;
        logic       interleave;
        logic [2:0] bl_code;
    } mode_t;

    localparam logic [2:0] BLC_FULL = 3'b111;

    // True when the length code and ordering form a supported pair.
    function automatic logic mode_legal(input logic [2:0] code, input logic il);
        return (code[2] == 1'b0) || ((code == BLC_FULL) && !il);
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
// Mode register: validates and stores a mode-set word.
// Assumes a mode-set is legal only while every bank is idle; rejected
// attempts keep the old contents and pulse mrs_err for one cycle.
module burst_mode_reg
    import burst_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int WORDW = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_cmd,
    input  logic [WORDW-1:0] mrs_word,
    input  logic [NBANK-1:0] bank_idle,
    output mode_t            mode,
    output logic             programmed,
    output logic             mrs_err
);
    logic all_idle;
    logic legal;
    logic accept;

    // Decide whether this mode-set may be taken.
    always_comb begin
        all_idle = &bank_idle;
        legal    = mode_legal(mrs_word[2:0], mrs_word[3]);
        accept   = mrs_cmd && all_idle && legal;
    end

    // Store the mode, the programmed status and the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= '0;
            programmed <= 1'b0;
            mrs_err    <= 1'b0;
        end else begin
            mrs_err <= mrs_cmd && !accept;
            if (accept) begin
                mode.bl_code    <= mrs_word[2:0];
                mode.interleave <= mrs_word[3];
                mode.cas        <= mrs_word[6:4];
                programmed      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat controller: tracks an active burst, its start column and beat index.
// Assumes the mode presented at a command edge is the one to use; a new
// command wins over burst_stop in the same cycle.
module burst_beat_ctrl
    import burst_pkg::*;
#(
    parameter int COLW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            go_wr,
    input  logic [COLW-1:0] start_col,
    input  mode_t           mode,
    input  logic            stop,
    output logic            active,
    output logic            is_wr,
    output logic [COLW-1:0] base,
    output logic [COLW-1:0] beat,
    output logic [COLW-1:0] mask,
    output logic            il
);
    logic [COLW-1:0] new_mask;
    logic            full_q;
    logic            last;

    // Turn the length code into a mask over the wrapping column bits.
    always_comb begin
        case (mode.bl_code)
            3'b000:  new_mask = '0;
            3'b001:  new_mask = COLW'(1);
            3'b010:  new_mask = COLW'(3);
            3'b011:  new_mask = COLW'(7);
            default: new_mask = '1;
        endcase
    end

    // A fixed-length burst ends when the beat index reaches its mask.
    always_comb last = !full_q && (beat == mask);

    // Start, advance and end bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            is_wr  <= 1'b0;
            base   <= '0;
            beat   <= '0;
            mask   <= '0;
            il     <= 1'b0;
            full_q <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            is_wr  <= go_wr;
            base   <= start_col;
            beat   <= '0;
            mask   <= new_mask;
            il     <= mode.interleave;
            full_q <= (mode.bl_code == BLC_FULL);
        end else if (active) begin
            if (stop || last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_addr_order.sv
// Column ordering: forms the beat's column from start, beat index and mask.
// Assumes beat never exceeds mask; bits outside the mask keep the start value.
module burst_addr_order #(
    parameter int COLW = 8
) (
    input  logic [COLW-1:0] base,
    input  logic [COLW-1:0] beat,
    input  logic [COLW-1:0] mask,
    input  logic            il,
    output logic [COLW-1:0] col
);
    logic [COLW-1:0] sum;

    // Sequential candidate: carries beyond the mask are dropped per bit.
    always_comb sum = base + beat;

    for (genvar i = 0; i < COLW; i++) begin : g_bit
        // Pick the bit source for one column bit.
        always_comb begin
            if (!mask[i])
                col[i] = base[i];
            else if (il)
                col[i] = base[i] ^ beat[i];
            else
                col[i] = sum[i];
        end
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the burst column generator: mode register, beat controller and
// column ordering. Assumes rd_cmd and wr_cmd are not raised together.
module sdram_burst_colgen
    import burst_pkg::*;
#(
    parameter int COLW  = 8,
    parameter int NBANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_cmd,
    input  logic [14:0]      mrs_word,
    input  logic [NBANK-1:0] bank_idle,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic [COLW-1:0]  start_col,
    input  logic             burst_stop,
    output logic             programmed,
    output logic             mrs_err,
    output logic [2:0]       cas_lat,
    output logic             col_valid,
    output logic             col_wr,
    output logic [COLW-1:0]  col_out
);
    mode_t           mode;
    logic            go;
    logic            active;
    logic            is_wr;
    logic            il;
    logic [COLW-1:0] base;
    logic [COLW-1:0] beat;
    logic [COLW-1:0] mask;

    // A command starts a burst only once a mode is loaded.
    always_comb go = (rd_cmd || wr_cmd) && programmed;

    burst_mode_reg #(.NBANK(NBANK), .WORDW(15)) u_mode (
        .clk(clk), .rst_n(rst_n), .mrs_cmd(mrs_cmd), .mrs_word(mrs_word),
        .bank_idle(bank_idle), .mode(mode), .programmed(programmed),
        .mrs_err(mrs_err)
    );

    burst_beat_ctrl #(.COLW(COLW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .go_wr(wr_cmd),
        .start_col(start_col), .mode(mode), .stop(burst_stop),
        .active(active), .is_wr(is_wr), .base(base), .beat(beat),
        .mask(mask), .il(il)
    );

    burst_addr_order #(.COLW(COLW)) u_order (
        .base(base), .beat(beat), .mask(mask), .il(il), .col(col_out)
    );

    // Drive the status and beat outputs.
    always_comb begin
        cas_lat   = mode.cas;
        col_valid = active;
        col_wr    = active && is_wr;
    end
endmodule

// File: rtl/burst_colgen_chk.sv
// Property checker for the burst column generator, bound to the top.
module burst_colgen_chk #(
    parameter int COLW  = 8,
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_cmd,
    input logic [14:0]      mrs_word,
    input logic [NBANK-1:0] bank_idle,
    input logic             rd_cmd,
    input logic             wr_cmd,
    input logic [COLW-1:0]  start_col,
    input logic             burst_stop,
    input logic             programmed,
    input logic             mrs_err,
    input logic [2:0]       cas_lat,
    input logic             col_valid,
    input logic [COLW-1:0]  col_out
);
    // R2
    prog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);
    // R3
    unprog_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!programmed && (rd_cmd || wr_cmd) && !col_valid) |=> !col_valid);
    // R4
    busy_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_cmd && !(&bank_idle)) |=> (mrs_err && $stable(cas_lat)));
    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_cmd && mrs_word[2] && (mrs_word[1:0] != 2'b11)) |=> (mrs_err && $stable(cas_lat)));
    // R6
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_cmd || wr_cmd) && programmed) |=> (col_valid && col_out == $past(start_col)));
    // R10
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && burst_stop && !rd_cmd && !wr_cmd) |=> !col_valid);
endmodule

bind sdram_burst_colgen burst_colgen_chk #(.COLW(COLW), .NBANK(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .mrs_cmd(mrs_cmd), .mrs_word(mrs_word),
    .bank_idle(bank_idle), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .start_col(start_col), .burst_stop(burst_stop), .programmed(programmed),
    .mrs_err(mrs_err), .cas_lat(cas_lat), .col_valid(col_valid),
    .col_out(col_out)
);

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;
    localparam int COLW  = 8;
    localparam int NBANK = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mrs_cmd = 1'b0;
    logic [14:0]      mrs_word = '0;
    logic [NBANK-1:0] bank_idle = '1;
    logic             rd_cmd = 1'b0;
    logic             wr_cmd = 1'b0;
    logic [COLW-1:0]  start_col = '0;
    logic             burst_stop = 1'b0;
    logic             programmed;
    logic             mrs_err;
    logic [2:0]       cas_lat;
    logic             col_valid;
    logic             col_wr;
    logic [COLW-1:0]  col_out;

    sdram_burst_colgen #(.COLW(COLW), .NBANK(NBANK)) dut (.*);

    always #2 clk = ~clk;

    int    vecs = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R2";

    // Reference model state.
    bit m_prog, m_err, m_act, m_wr, m_il, m_full, m_go, m_ok, m_legal;
    int m_code, m_mil, m_cas, m_base, m_n, m_len;

    function automatic int bl_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 256;
        endcase
    endfunction

    function automatic int exp_col();
        int lowpart;
        if (m_full) return (m_base + m_n) % 256;
        lowpart = m_base % m_len;
        if (m_il) return m_base - lowpart + (lowpart ^ m_n);
        return m_base - lowpart + ((lowpart + m_n) % m_len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prog = 0; m_err = 0; m_act = 0; m_wr = 0;
            m_code = 0; m_mil = 0; m_cas = 0; m_n = 0;
        end else begin
            m_go = (rd_cmd || wr_cmd) && m_prog;
            if (m_go) begin
                m_act = 1; m_base = start_col; m_n = 0; m_wr = wr_cmd;
                m_len = bl_of(m_code); m_full = (m_code == 7); m_il = (m_mil != 0);
            end else if (m_act) begin
                if (burst_stop) m_act = 0;
                else if (!m_full && m_n == m_len - 1) m_act = 0;
                else m_n = (m_n + 1) % 256;
            end
            m_legal = (mrs_word[2:0] < 4) || (mrs_word[2:0] == 7 && !mrs_word[3]);
            m_ok    = mrs_cmd && (&bank_idle) && m_legal;
            m_err   = mrs_cmd && !m_ok;
            if (m_ok) begin
                m_code = int'(mrs_word[2:0]); m_mil = int'(mrs_word[3]);
                m_cas = int'(mrs_word[6:4]); m_prog = 1;
            end
        end
    end

    task automatic cmp(input string what, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Sample outputs away from the active edge and compare with the model.
    task automatic tick();
        @(negedge clk);
        cmp("programmed", int'(programmed), int'(m_prog));
        cmp("mrs_err", int'(mrs_err), int'(m_err));
        cmp("cas_lat", int'(cas_lat), m_cas);
        cmp("col_valid", int'(col_valid), int'(m_act));
        if (m_act) begin
            cmp("col_out", int'(col_out), exp_col());
            cmp("col_wr", int'(col_wr), int'(m_wr));
        end
        mrs_cmd = 0; rd_cmd = 0; wr_cmd = 0; burst_stop = 0; bank_idle = '1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic mrs(input int code, input int il, input int cas);
        mrs_cmd = 1;
        mrs_word = {2'b10, 6'b101101, 3'(cas), 1'(il), 3'(code)};
        tick();
    endtask

    task automatic cmd(input bit wr, input int col);
        rd_cmd = !wr; wr_cmd = wr; start_col = COLW'(col);
        tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        tag = "R2"; rst_n = 0; idle(3); rst_n = 1; idle(1);
        tag = "R3"; cmd(0, 5); cmd(1, 9); idle(2);
        tag = "R4"; bank_idle = 4'b1011; mrs_cmd = 1;
        mrs_word = {2'b00, 6'd0, 3'd2, 1'b0, 3'd2}; tick(); idle(2);
        tag = "R5"; mrs(4, 0, 2); mrs(5, 0, 2); mrs(6, 1, 2); mrs(7, 1, 2); idle(1);
        tag = "R1"; mrs(2, 0, 3); idle(1);
        tag = "R5"; mrs(6, 0, 5); idle(1);
        tag = "R7"; cmd(0, 45); idle(5);
        tag = "R1"; mrs(3, 0, 2); idle(1);
        tag = "R7"; cmd(0, 254); idle(9);
        tag = "R8"; mrs(3, 1, 1); cmd(0, 53); idle(9);
        tag = "R8"; mrs(1, 1, 1); cmd(0, 77); idle(3);
        tag = "R6"; mrs(0, 0, 4); cmd(0, 200); idle(2);
        tag = "R6"; mrs(1, 0, 4); cmd(1, 33); idle(3);
        tag = "R9"; mrs(7, 0, 6); cmd(0, 252); idle(9);
        burst_stop = 1; tick(); idle(2);
        tag = "R9"; cmd(0, 10); idle(300); burst_stop = 1; tick(); idle(1);
        tag = "R10"; mrs(3, 0, 2); cmd(0, 16); idle(2); burst_stop = 1; tick(); idle(3);
        tag = "R11"; cmd(0, 100); idle(3); cmd(1, 7); idle(10);
        tag = "R11"; cmd(0, 40); idle(2);
        rd_cmd = 1; start_col = 8'd90; burst_stop = 1; mrs_cmd = 1;
        mrs_word = {2'b00, 6'd0, 3'd3, 1'b1, 3'd2}; tick(); idle(10);
        tag = "R12"; cmd(1, 128); idle(3); cmd(0, 129); idle(10);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule